// File: doc/BRIEF.md
# FEC Decoder Input Recovery Controller

This block sits in front of the input FIFO and the frame aligner of a forward-error-correction decoder. It decides what happens to the decoder's input when the line degrades. It registers six status inputs on entry: loss of signal, loss of frame, FIFO overflow, FIFO underflow, clock-recovery lock and a bypass-mode flag. From these it gates the incoming data word to zero, or it asks the surrounding logic to recover from a FIFO spill.

A spill is an overflow or an underflow. Recovery from a spill is either a new frame alignment or a FIFO pointer reset. The block issues each request as a one-cycle pulse. A sticky alarm records every spill, whether or not recovery is enabled. One 16-bit configuration word on a small register bus selects the policy. A second address exposes the alarm, which is cleared by writing one to it.

Top module: `fecin_recovery_ctl`

## Requirements
- R1: After reset the configuration word (address 0) reads 0x3800, the alarm word (address 1) reads 0, and both request outputs are low.
- R2: At address 0 only bits 15:11 are writable. Bits 10:0 always read as zero. Any other address reads zero.
- R3: With configuration bit 15 set, `dout` is all zeros in every cycle whose registered loss-of-signal is high (one clock edge after `sig_loss` rises). With bit 15 clear, loss of signal leaves `dout` equal to `din`.
- R4: With configuration bit 14 set, `dout` is all zeros while the registered loss-of-frame is high. With bit 14 clear, loss of frame leaves `dout` equal to `din`.
- R5: Any FIFO overflow or underflow sets `spill_alarm` (bit 0 of address 1), whatever the configuration. The alarm stays set until a write to address 1 with data bit 0 at one. A spill in the same cycle as the clear wins.
- R6: With configuration bit 13 clear, no spill produces a request.
- R7: With bits 13 and 12 both set, a spill produces a request only if the registered lock input is high. With bit 12 clear, lock is ignored.
- R8: Configuration bit 11 at one selects a new-frame-alignment request. At zero it selects a pointer-reset request, but only when bypass mode is active. Without bypass mode, a new-frame-alignment request is issued instead.
- R9: A request is a single-cycle pulse. It appears two clock edges after the spill input rises, and no further request follows until the spill indication has gone low.
- R10: The two request outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 configuration, 1 alarm) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| sig_loss | input | 1 | Loss of signal |
| frm_loss | input | 1 | Loss of frame |
| fifo_ovf | input | 1 | Input FIFO overflow |
| fifo_udf | input | 1 | Input FIFO underflow |
| cdr_lock | input | 1 | Clock-recovery lock |
| bypass_mode | input | 1 | Decoder bypass mode active |
| din | input | DATA_W | Data word toward the decoder |
| dout | output | DATA_W | Gated data word to the decoder |
| realign_req | output | 1 | One-cycle new-frame-alignment request |
| ptr_rst_req | output | 1 | One-cycle FIFO pointer-reset request |
| spill_alarm | output | 1 | Sticky FIFO-spill alarm |

## Verification
The assertions check several properties on every cycle:
- the two requests never coincide;
- each request lasts exactly one cycle;
- a request never appears without the alarm;
- a pointer reset only follows bypass mode;
- the alarm survives every cycle without a clear;
- the data gate is zero whenever an enabled loss condition was registered.

Only the bench's sweeps can show the rest. These are:
- the full mapping from the policy bits, lock and bypass to the exact request chosen, or its absence;
- the latency of two edges;
- the set-over-clear priority of the alarm;
- the read-back masking of the configuration word.

// File: rtl/fecin_recovery_ctl.sv
module fecin_recovery_ctl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              sig_loss,
  input  logic              frm_loss,
  input  logic              fifo_ovf,
  input  logic              fifo_udf,
  input  logic              cdr_lock,
  input  logic              bypass_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              realign_req,
  output logic              ptr_rst_req,
  output logic              spill_alarm
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ALM_ADDR = ADDR_W'(1);
  localparam logic [4:0]        CFG_RST  = 5'b00111;

  logic [4:0] cfg_q;
  logic sig_q, frm_q, ovf_q, udf_q, lock_q, byp_q, spill_d;
  logic spill, spill_rise, recover_en, alarm_clr;

  wire zero_sig  = cfg_q[4];
  wire zero_frm  = cfg_q[3];
  wire auto_rec  = cfg_q[2];
  wire lock_gate = cfg_q[1];
  wire use_align = cfg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sig_q, frm_q, ovf_q, udf_q, lock_q, byp_q} <= '0;
    end else begin
      sig_q  <= sig_loss;
      frm_q  <= frm_loss;
      ovf_q  <= fifo_ovf;
      udf_q  <= fifo_udf;
      lock_q <= cdr_lock;
      byp_q  <= bypass_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= CFG_RST;
    else if (reg_wr && reg_addr == CFG_ADDR)
      cfg_q <= reg_wdata[15:11];
  end

  assign alarm_clr = reg_wr && reg_addr == ALM_ADDR && reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_ADDR)      reg_rdata = {cfg_q, 11'd0};
    else if (reg_addr == ALM_ADDR) reg_rdata = {15'd0, spill_alarm};
  end

  assign dout = ((zero_sig && sig_q) || (zero_frm && frm_q)) ? '0 : din;

  assign spill      = ovf_q | udf_q;
  assign spill_rise = spill & ~spill_d;
  assign recover_en = auto_rec & (~lock_gate | lock_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spill_d     <= 1'b0;
      realign_req <= 1'b0;
      ptr_rst_req <= 1'b0;
      spill_alarm <= 1'b0;
    end else begin
      spill_d     <= spill;
      realign_req <= spill_rise & recover_en & (use_align | ~byp_q);
      ptr_rst_req <= spill_rise & recover_en & ~use_align & byp_q;
      spill_alarm <= spill | (spill_alarm & ~alarm_clr);
    end
  end
endmodule

// File: rtl/fecin_recovery_ctl_chk.sv
module fecin_recovery_ctl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              sig_loss,
  input logic              frm_loss,
  input logic              bypass_mode,
  input logic [4:0]        cfg_q,
  input logic [DATA_W-1:0] dout,
  input logic              realign_req,
  input logic              ptr_rst_req,
  input logic              spill_alarm
);
  assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({realign_req, ptr_rst_req}));

  assert_align_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    realign_req |=> !realign_req);

  assert_ptr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst_req |=> !ptr_rst_req);

  assert_req_has_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_req || ptr_rst_req) |-> spill_alarm);

  assert_alarm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_alarm && !(reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[0])) |=> spill_alarm);

  assert_ptr_needs_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst_req |-> $past(bypass_mode, 2));

  assert_sig_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[4] && $past(sig_loss)) |-> dout == '0);

  assert_frm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[3] && $past(frm_loss)) |-> dout == '0);
endmodule

bind fecin_recovery_ctl fecin_recovery_ctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sig_loss(sig_loss), .frm_loss(frm_loss), .bypass_mode(bypass_mode), .cfg_q(cfg_q),
  .dout(dout), .realign_req(realign_req), .ptr_rst_req(ptr_rst_req), .spill_alarm(spill_alarm)
);

// File: tb/fecin_recovery_ctl_tb.sv
`timescale 1ns/1ps
module fecin_recovery_ctl_tb;
  localparam int DW = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic sig_loss = 0, frm_loss = 0, fifo_ovf = 0, fifo_udf = 0, cdr_lock = 0, bypass_mode = 0;
  logic [DW-1:0] din = '0, dout;
  logic realign_req, ptr_rst_req, spill_alarm;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  fecin_recovery_ctl #(.DATA_W(DW), .ADDR_W(AW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    @(negedge clk); reg_addr = a; #0.5; chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(4ns * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1", 0, 16'h3800);
    rd_chk("R1", 1, 16'h0000);
    chk("R1", {realign_req, ptr_rst_req}, 0);
    // R2 masking
    wr(0, 16'hFFFF); rd_chk("R2", 0, 16'hF800);
    wr(0, 16'h07FF); rd_chk("R2", 0, 16'h0000);
    wr(0, 16'hA800); rd_chk("R2", 0, 16'hA800);
    rd_chk("R2", 5, 16'h0000);

    // R3/R4 data gate sweep
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 4; l++) begin
        logic [15:0] pat;
        logic z;
        wr(0, {c[1], c[0], 3'b111, 11'd0});
        @(negedge clk); sig_loss = l[0]; frm_loss = l[1];
        @(negedge clk);
        pat = 16'h1234 ^ (16'h0F0F * (c * 4 + l + 1));
        din = pat; #0.5;
        z = (c[1] & l[0]) | (c[0] & l[1]);
        chk(l[1] ? "R4" : "R3", dout, z ? 16'h0 : pat);
        @(negedge clk); sig_loss = 0; frm_loss = 0;
        @(negedge clk); #0.5;
        chk("R3", dout, pat);
      end

    // R5..R9 policy sweep
    for (int cfg = 0; cfg < 32; cfg++)
      for (int e = 0; e < 8; e++) begin
        int na, np;
        logic en;
        int exp_a, exp_p;
        wr(0, {cfg[4:0], 11'd0});
        @(negedge clk); cdr_lock = e[0]; bypass_mode = e[1];
        wr(1, 16'h0001);
        @(negedge clk);
        chk("R5", spill_alarm, 0);
        if (e[2]) fifo_udf = 1; else fifo_ovf = 1;
        na = 0; np = 0;
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (k == 1) begin
            en = cfg[2] & (~cfg[1] | e[0]);
            chk("R9", realign_req, en & (cfg[0] | ~e[1]));
            chk("R9", ptr_rst_req, en & ~cfg[0] & e[1]);
          end
          na += realign_req; np += ptr_rst_req;
          if (k == 3) begin fifo_ovf = 0; fifo_udf = 0; end
        end
        en = cfg[2] & (~cfg[1] | e[0]);
        exp_a = en & (cfg[0] | ~e[1]);
        exp_p = en & ~cfg[0] & e[1];
        chk(cfg[2] ? (cfg[1] ? "R7" : "R8") : "R6", na, exp_a);
        chk(cfg[2] ? (cfg[1] ? "R7" : "R8") : "R6", np, exp_p);
        chk("R5", spill_alarm, 1);
      end

    // R5 set wins over clear, write of 0 does not clear
    @(negedge clk); fifo_ovf = 1;
    repeat (2) @(negedge clk);
    wr(1, 16'h0001); #0.5; chk("R5", spill_alarm, 1);
    fifo_ovf = 0; repeat (2) @(negedge clk);
    wr(1, 16'h0000); #0.5; chk("R5", spill_alarm, 1);
    rd_chk("R5", 1, 16'h0001);
    wr(1, 16'h0001); #0.5; chk("R5", spill_alarm, 0);

    // R9 overflow then underflow back to back: no second request
    wr(0, 16'h2800);
    @(negedge clk); fifo_ovf = 1;
    begin
      int n = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (k == 2) begin fifo_ovf = 0; fifo_udf = 1; end
        n += realign_req;
      end
      fifo_udf = 0;
      chk("R9", n, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule